// File: doc/BRIEF.md
# Head Seek Step Sequencer

The sequencer moves a disk drive head across a programmed number of tracks. While idle the host loads the number of tracks to travel into a magnitude counter. It picks the travel direction with a drive action code: one code selects travel toward higher tracks and another selects travel toward lower tracks. A rising edge on the start control level then begins the seek. Pulse timing is derived from a one-microsecond tick input.

During a seek the block sends one step strobe to the drive for each track and drives the drive select lines with the step code. After each strobe falls it lowers the live counter, which the host can read at any time. When the counter reaches zero, stepping stops even if the start level is still high, and a one-cycle seek-done pulse is raised. Dropping the start level during a seek aborts it. No further strobes follow, the remaining count is kept and no done pulse is raised.

Top module: `seek_stepper`

## Requirements
- R1: After reset the step strobe is low, the count reads 0, the done pulse is low, the direction level is 0 (toward higher tracks) and the select lines read 3 (relaxed).
- R2: While idle, a count write loads the count output with the written value, and the value can be read back before any seek.
- R3: While idle, an action load with code 0 sets the direction level to 0, and code 4 sets it to 1 (toward lower tracks). Any other code leaves the direction level unchanged.
- R4: A rising edge of start with a nonzero count N produces exactly N step strobes. Each strobe is high for PULSE_TICKS ticks, and strobes start PERIOD_TICKS ticks apart.
- R5: The count falls by exactly one at each falling edge of the step strobe, and it changes at no other time during a seek.
- R6: When the count reaches zero the done output is high for exactly one cycle. No further strobes follow while start stays high.
- R7: A rising edge of start with a count of 0 raises done one clock later and produces no strobe.
- R8: Dropping start during a seek stops the strobes. The remaining count is kept and done is not raised.
- R9: During a seek, count writes and action loads are ignored: the count keeps decrementing from its seek value and the direction level holds.
- R10: The select lines read 1 (step) while a seek is in progress and 3 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| cnt_wr | input | 1 | Count register write strobe |
| cnt_wdata | input | CNT_W | Number of tracks to step |
| act_load | input | 1 | Drive action code strobe |
| act_code | input | 4 | Drive action code (0 = up, 4 = down) |
| start | input | 1 | Seek start control level |
| step_o | output | 1 | Step strobe to the drive |
| dir_o | output | 1 | Direction level, 1 = toward lower tracks |
| sel_o | output | 3 | Drive select lines |
| count_o | output | CNT_W | Tracks still to step |
| done_o | output | 1 | One-cycle seek-done pulse |

## Verification
If the tick phase is wrong, it shows within one step period as a strobe of the wrong width or spacing. If the count is wrong, it shows as a wrong number of strobes, or as done arriving early or late. If the busy state is wrong, strobes continue after done or after an abort, or the count changes in response to a write during a seek. If the direction register is wrong, it shows at once on dir_o after an action load.

// File: rtl/seek_stepper.sv
module seek_stepper #(
  parameter int CNT_W        = 8,
  parameter int PERIOD_TICKS = 3000,
  parameter int PULSE_TICKS  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             us_tick,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             act_load,
  input  logic [3:0]       act_code,
  input  logic             start,
  output logic             step_o,
  output logic             dir_o,
  output logic [2:0]       sel_o,
  output logic [CNT_W-1:0] count_o,
  output logic             done_o
);

  localparam int TW = $clog2(PERIOD_TICKS + 1);
  localparam logic [TW-1:0] LAST_HI  = TW'(PULSE_TICKS - 1);
  localparam logic [TW-1:0] LAST_PER = TW'(PERIOD_TICKS - 1);
  localparam logic [TW-1:0] HI_LIM   = TW'(PULSE_TICKS);

  logic             busy, start_q, done_q, dir_q;
  logic [TW-1:0]    tcnt;
  logic [CNT_W-1:0] count;

  wire start_rise = start & ~start_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      start_q <= 1'b0;
      done_q  <= 1'b0;
      dir_q   <= 1'b0;
      tcnt    <= '0;
      count   <= '0;
    end else begin
      start_q <= start;
      done_q  <= 1'b0;
      if (!busy) begin
        if (cnt_wr) count <= cnt_wdata;
        if (act_load && act_code == 4'd0) dir_q <= 1'b0;
        else if (act_load && act_code == 4'd4) dir_q <= 1'b1;
        if (start_rise) begin
          if (count == '0) done_q <= 1'b1;
          else begin
            busy <= 1'b1;
            tcnt <= '0;
          end
        end
      end else if (!start) begin
        busy <= 1'b0;
      end else if (us_tick) begin
        if (tcnt == LAST_HI) begin
          count <= count - CNT_W'(1);
          if (count == CNT_W'(1)) begin
            busy   <= 1'b0;
            done_q <= 1'b1;
          end
        end
        tcnt <= (tcnt == LAST_PER) ? '0 : tcnt + TW'(1);
      end
    end
  end

  assign step_o  = busy && (tcnt < HI_LIM);
  assign dir_o   = dir_q;
  assign sel_o   = busy ? 3'd1 : 3'd3;
  assign count_o = count;
  assign done_o  = done_q;

  p_done_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> count_o == '0);

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && count_o != $past(count_o)) |-> (count_o == $past(count_o) - CNT_W'(1)));

  p_count_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && count_o != $past(count_o)) |-> $fell(step_o));

  p_dir_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy) |-> $stable(dir_o));

  p_abort_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && $past(!start)) |-> (!step_o && sel_o == 3'd3));

endmodule

// File: tb/seek_stepper_bench.sv
`timescale 1ns/100ps
module seek_stepper_bench;
  localparam int CW  = 8;
  localparam int PER = 12;
  localparam int PW  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic us_tick = 1'b1;
  logic cnt_wr = 1'b0;
  logic [CW-1:0] cnt_wdata = '0;
  logic act_load = 1'b0;
  logic [3:0] act_code = '0;
  logic start = 1'b0;
  logic step_o, dir_o, done_o;
  logic [2:0] sel_o;
  logic [CW-1:0] count_o;

  int checks = 0, fails = 0;
  int pulses = 0, width_err = 0, period_err = 0, dones = 0;
  int hi_len = 0, gap = 0;
  logic prev_step = 1'b0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  seek_stepper #(.CNT_W(CW), .PERIOD_TICKS(PER), .PULSE_TICKS(PW)) u_seek_stepper (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .act_load(act_load), .act_code(act_code), .start(start), .step_o(step_o),
    .dir_o(dir_o), .sel_o(sel_o), .count_o(count_o), .done_o(done_o));

  always @(negedge clk) begin
    gap <= gap + 1;
    if (step_o && !prev_step) begin
      if (pulses > 0 && gap != PER) period_err <= period_err + 1;
      pulses <= pulses + 1;
      gap <= 1;
    end
    if (step_o) hi_len <= hi_len + 1;
    if (!step_o && prev_step) begin
      if (hi_len != PW) width_err <= width_err + 1;
      hi_len <= 0;
    end
    if (done_o) dones <= dones + 1;
    prev_step <= step_o;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_count(input int v);
    @(negedge clk); cnt_wr = 1'b1; cnt_wdata = CW'(v);
    @(negedge clk); cnt_wr = 1'b0;
  endtask

  task automatic load_act(input int c);
    @(negedge clk); act_load = 1'b1; act_code = 4'(c);
    @(negedge clk); act_load = 1'b0;
  endtask

  task automatic clear_stats();
    @(negedge clk);
    pulses = 0; width_err = 0; period_err = 0; dones = 0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int i = 0; i < 4000 && !seen; i++) begin
      @(negedge clk);
      if (done_o) seen = 1;
    end
  endtask

  // R4 R3 R2: count, action code, expected direction
  localparam logic [15:0] VEC [0:3] = '{16'h0300, 16'h0141, 16'h0500, 16'h0241};

  initial begin
    bit seen;
    int c0;
    repeat (3) @(negedge clk);
    check("R1 step", step_o, 0);
    check("R1 count", count_o, 0);
    check("R1 done", done_o, 0);
    check("R1 dir", dir_o, 0);
    check("R1 sel", sel_o, 3);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 4; v++) begin
      wr_count(VEC[v][15:8]);
      check("R2 readback", count_o, VEC[v][15:8]);
      load_act(VEC[v][7:4]);
      check("R3 dir", dir_o, VEC[v][3:0]);
      clear_stats();
      start = 1'b1;
      @(negedge clk);
      check("R10 sel busy", sel_o, 1);
      wait_done(seen);
      check("R6 done seen", seen, 1);
      check("R6 count zero", count_o, 0);
      @(negedge clk);
      check("R6 done width", done_o, 0);
      repeat (3 * PER) @(negedge clk);
      check("R4 pulses", pulses, VEC[v][15:8]);
      check("R4 width", width_err, 0);
      check("R4 period", period_err, 0);
      check("R6 single done", dones, 1);
      check("R10 sel idle", sel_o, 3);
      start = 1'b0;
      @(negedge clk);
    end

    load_act(9);
    check("R3 other code", dir_o, 1);
    load_act(13);
    check("R3 other code", dir_o, 1);

    // R7 zero count
    clear_stats();
    check("R7 count", count_o, 0);
    start = 1'b1;
    @(negedge clk);
    check("R7 done", done_o, 1);
    @(negedge clk);
    check("R7 done drop", done_o, 0);
    repeat (2 * PER) @(negedge clk);
    check("R7 no pulse", pulses, 0);
    start = 1'b0;
    @(negedge clk);

    // R8 abort after two pulses
    wr_count(5);
    clear_stats();
    start = 1'b1;
    for (int i = 0; i < 200 && !(pulses == 2 && !step_o); i++) @(negedge clk);
    check("R5 live count", count_o, 3);
    start = 1'b0;
    repeat (4 * PER) @(negedge clk);
    check("R8 pulses", pulses, 2);
    check("R8 count kept", count_o, 3);
    check("R8 no done", dones, 0);
    check("R8 sel", sel_o, 3);

    // R9 writes ignored during seek
    wr_count(4);
    load_act(0);
    clear_stats();
    start = 1'b1;
    repeat (2) @(negedge clk);
    cnt_wr = 1'b1; cnt_wdata = 8'd9; act_load = 1'b1; act_code = 4'd4;
    @(negedge clk);
    cnt_wr = 1'b0; act_load = 1'b0;
    @(negedge clk);
    c0 = count_o;
    check("R9 count ignored", (c0 <= 4) ? 1 : 0, 1);
    check("R9 dir ignored", dir_o, 0);
    wait_done(seen);
    check("R9 done", seen, 1);
    @(negedge clk);
    check("R9 pulses", pulses, 4);
    check("R5 final count", count_o, 0);
    start = 1'b0;
    @(negedge clk);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule